// File: doc/BRIEF.md
# MSI-X Outbound Interrupt Message Generator

This block turns outbound interrupt status lines into message-signalled interrupts. It holds a small vector table and a pending-bit array inside an 8 KB device window. A host reaches both through a word-addressed slave register port. A rising status bit selects a vector. If the vector is open, the block issues one single-beat memory-write request that carries the vector's programmed address and data. If the vector is masked, or all vectors are masked by the function mask, the event is remembered in the pending array and is sent once the mask opens.

Status bit n drives vector n. Vector 2 is shared between the doorbell source (bit 2) and the firmware source (bit 31). When message signalling is off, the block drives a legacy active-low level interrupt from the unmasked status bits instead. When signalling is on, that interrupt stays quiet.

Top module: `msix_msg_gen`

## Requirements
- R1: A message is a write request whose 64-bit address is {address-high word, address-low word} of the selected vector and whose data is the vector's data word.
- R2: A rising edge on status bit n (n < NUM_VEC) triggers vector n. Rising edges on bits NUM_VEC..30 trigger nothing.
- R3: Bits 2 and 31 both trigger vector 2. When both rise in the same cycle, exactly one message is sent.
- R4: The vector table is at byte offset 0x1000 (word address 0x400), with 16 bytes per vector. The words are address-low (+0), address-high (+4), data (+8) and control (+12). Control bit 0 is the per-vector mask, and it resets to 1. Unimplemented vectors and the lower 4 KB read as zero.
- R5: The pending array is at byte offset 0x1800 (word address 0x600). Bit i of its first word is vector i's pending flag. Host writes to it are ignored.
- R6: An event on a masked vector, or any event while the function mask is set, sets the pending flag and sends no message.
- R7: When a vector with its pending flag set becomes unmasked, exactly one message is sent and the flag clears.
- R8: When several vectors are ready together, the lowest index is sent first. Only one request is outstanding at a time, and valid drops for at least one cycle after each handshake.
- R9: While valid is high and ready is low, valid, address and data hold steady.
- R10: An event on a vector that is already pending, queued or in flight adds no further message.
- R11: While message signalling is enabled, intx_n stays high. While it is disabled, intx_n is low exactly when some status bit is set and not masked by irq_mask.
- R12: While message signalling is disabled, status edges produce neither messages nor pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when high, read otherwise |
| reg_waddr | input | 11 | Word address within the 8 KB window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_waddr (combinational) |
| msix_en | input | 1 | Message signalling enable |
| func_mask | input | 1 | Function-wide vector mask |
| irq_status | input | 32 | Outbound interrupt status bits |
| irq_mask | input | 32 | Legacy interrupt mask, 1 = masked |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 64 | Message address |
| wr_data | output | 32 | Message data |
| intx_n | output | 1 | Legacy active-low interrupt |

## Verification
The bench applies single-bit patterns that show the bit-to-vector mapping, including the shared bit 31, and multi-bit bursts whose message order shows the priority encoder. A pattern using bits above the table size should produce silence, and a simultaneous bit 2 and bit 31 edge separates one message from a duplicate. Directed sequences then exercise masked and pending events, re-triggering while a message is pending or stalled, writes to the read-only pending array, and the legacy interrupt in both signalling modes.

// File: rtl/msix_pkg.sv
package msix_pkg;
  // Region select taken from word-address bits [10:9]
  localparam logic [1:0] RGN_TABLE = 2'b10;
  localparam logic [1:0] RGN_PBA   = 2'b11;
  // Vector that two status sources share
  localparam int unsigned SHARED_VEC = 2;

  typedef struct packed {
    logic [31:0] addr_lo;
    logic [31:0] addr_hi;
    logic [31:0] data;
    logic        mask;
  } vec_entry_t;
endpackage

// File: rtl/msix_table.sv
module msix_table
  import msix_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [10:0]              waddr,
  input  logic [31:0]              wdata,
  input  logic [NUM_VEC-1:0]       pend,
  output logic [31:0]              rdata,
  output logic [NUM_VEC-1:0][63:0] vec_addr,
  output logic [NUM_VEC-1:0][31:0] vec_data,
  output logic [NUM_VEC-1:0]       vec_mask
);
  logic [1:0] region;
  logic [6:0] eidx;
  logic [1:0] word;
  assign region = waddr[10:9];
  assign eidx   = waddr[8:2];
  assign word   = waddr[1:0];

  vec_entry_t ent_q [NUM_VEC];

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
    logic       sel;
    vec_entry_t ent_d;
    assign sel = wr_en && (region == RGN_TABLE) && (eidx == 7'(g));

    always_comb begin
      ent_d = ent_q[g];
      case (word)
        2'd0:    ent_d.addr_lo = wdata;
        2'd1:    ent_d.addr_hi = wdata;
        2'd2:    ent_d.data    = wdata;
        default: ent_d.mask    = wdata[0];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g].addr_lo <= '0;
        ent_q[g].addr_hi <= '0;
        ent_q[g].data    <= '0;
        ent_q[g].mask    <= 1'b1;
      end else if (sel) begin
        ent_q[g] <= ent_d;
      end
    end

    assign vec_addr[g] = {ent_q[g].addr_hi, ent_q[g].addr_lo};
    assign vec_data[g] = ent_q[g].data;
    assign vec_mask[g] = ent_q[g].mask;
  end

  always_comb begin
    rdata = '0;
    if (region == RGN_TABLE) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        if (eidx == 7'(i)) begin
          case (word)
            2'd0:    rdata = ent_q[i].addr_lo;
            2'd1:    rdata = ent_q[i].addr_hi;
            2'd2:    rdata = ent_q[i].data;
            default: rdata = {31'b0, ent_q[i].mask};
          endcase
        end
      end
    end else if (region == RGN_PBA && waddr[8:0] == 9'd0) begin
      rdata = 32'(pend);
    end
  end
endmodule

// File: rtl/msix_vec_ctl.sv
module msix_vec_ctl
  import msix_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC:0]   src,       // [NUM_VEC] is the shared second source
  input  logic               msix_en,
  input  logic               func_mask,
  input  logic [NUM_VEC-1:0] vec_mask,
  input  logic [NUM_VEC-1:0] grant,
  input  logic [NUM_VEC-1:0] inflight,
  output logic [NUM_VEC-1:0] pend,
  output logic [NUM_VEC-1:0] req
);
  logic [NUM_VEC:0]   src_q;
  logic [NUM_VEC:0]   rise;
  logic [NUM_VEC-1:0] pend_q, pend_d, req_q, req_d;

  assign rise = src & ~src_q;

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
    logic ev, blocked, busy;
    if (g == SHARED_VEC) begin : g_shared
      assign ev = rise[g] | rise[NUM_VEC];
    end else begin : g_plain
      assign ev = rise[g];
    end
    assign blocked = vec_mask[g] | func_mask;
    assign busy    = req_q[g] | pend_q[g] | inflight[g];

    always_comb begin
      pend_d[g] = pend_q[g];
      req_d[g]  = req_q[g] & ~grant[g];
      if (msix_en) begin
        if (ev && !busy) begin
          if (blocked) pend_d[g] = 1'b1;
          else         req_d[g]  = 1'b1;
        end else if (pend_q[g] && !blocked) begin
          pend_d[g] = 1'b0;
          req_d[g]  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
      req_q  <= '0;
    end else begin
      src_q  <= src;
      pend_q <= pend_d;
      req_q  <= req_d;
    end
  end

  assign pend = pend_q;
  assign req  = req_q;
endmodule

// File: rtl/msix_arb_out.sv
module msix_arb_out #(
  parameter int unsigned NUM_VEC = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_VEC-1:0]       req,
  input  logic [NUM_VEC-1:0][63:0] vec_addr,
  input  logic [NUM_VEC-1:0][31:0] vec_data,
  input  logic                     wr_ready,
  output logic [NUM_VEC-1:0]       grant,
  output logic [NUM_VEC-1:0]       inflight,
  output logic                     wr_valid,
  output logic [63:0]              wr_addr,
  output logic [31:0]              wr_data
);
  localparam logic [NUM_VEC-1:0] ONE = 1;

  logic               busy_q, busy_d, launch;
  logic [NUM_VEC-1:0] infl_q, infl_d;
  logic [63:0]        addr_q, addr_sel;
  logic [31:0]        data_q, data_sel;

  // Lowest set request bit, only while the output stage is free
  assign grant  = busy_q ? '0 : (req & (~req + ONE));
  assign launch = |grant;

  always_comb begin
    addr_sel = '0;
    data_sel = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (grant[i]) begin
        addr_sel = addr_sel | vec_addr[i];
        data_sel = data_sel | vec_data[i];
      end
    end
  end

  always_comb begin
    busy_d = busy_q;
    infl_d = infl_q;
    if (busy_q && wr_ready) begin
      busy_d = 1'b0;
      infl_d = '0;
    end
    if (launch) begin
      busy_d = 1'b1;
      infl_d = grant;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      infl_q <= '0;
    end else begin
      busy_q <= busy_d;
      infl_q <= infl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (launch) begin
      addr_q <= addr_sel;
      data_q <= data_sel;
    end
  end

  assign inflight = infl_q;
  assign wr_valid = busy_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
endmodule

// File: rtl/msix_msg_gen.sv
module msix_msg_gen #(
  parameter int unsigned NUM_VEC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_req,
  input  logic        reg_we,
  input  logic [10:0] reg_waddr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        msix_en,
  input  logic        func_mask,
  input  logic [31:0] irq_status,
  input  logic [31:0] irq_mask,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [63:0] wr_addr,
  output logic [31:0] wr_data,
  output logic        intx_n
);
  localparam int unsigned SHARED_BIT = 31;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [NUM_VEC-1:0]       pba_bits, req_bits, grant, inflight, vec_mask;
  logic [NUM_VEC-1:0][63:0] vec_addr;
  logic [NUM_VEC-1:0][31:0] vec_data;
  logic [NUM_VEC:0]         src;

  assign src = {irq_status[SHARED_BIT], irq_status[NUM_VEC-1:0]};

  msix_table #(.NUM_VEC(NUM_VEC)) u_table (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (reg_req & reg_we),
    .waddr    (reg_waddr),
    .wdata    (reg_wdata),
    .pend     (pba_bits),
    .rdata    (reg_rdata),
    .vec_addr (vec_addr),
    .vec_data (vec_data),
    .vec_mask (vec_mask)
  );

  msix_vec_ctl #(.NUM_VEC(NUM_VEC)) u_vec (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .src       (src),
    .msix_en   (msix_en),
    .func_mask (func_mask),
    .vec_mask  (vec_mask),
    .grant     (grant),
    .inflight  (inflight),
    .pend      (pba_bits),
    .req       (req_bits)
  );

  msix_arb_out #(.NUM_VEC(NUM_VEC)) u_arb (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req      (req_bits),
    .vec_addr (vec_addr),
    .vec_data (vec_data),
    .wr_ready (wr_ready),
    .grant    (grant),
    .inflight (inflight),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  // Legacy level interrupt, silenced while message signalling is on
  assign intx_n = ~(~msix_en & (|(irq_status & ~irq_mask)));
endmodule

// File: rtl/msix_msg_gen_chk.sv
module msix_msg_gen_chk #(
  parameter int unsigned NUM_VEC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msix_en,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [63:0]        wr_addr,
  input logic [31:0]        wr_data,
  input logic               intx_n,
  input logic [NUM_VEC-1:0] pba_bits,
  input logic [NUM_VEC-1:0] req_bits
);
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_gap_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !wr_valid);

  p_intx_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msix_en |-> intx_n);

  p_no_dup_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pba_bits & req_bits) == '0);

  p_pba_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !msix_en |=> $stable(pba_bits));
endmodule

bind msix_msg_gen msix_msg_gen_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .msix_en  (msix_en),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .intx_n   (intx_n),
  .pba_bits (pba_bits),
  .req_bits (req_bits)
);

// File: tb/sim_msix_msg_gen.sv
`timescale 1ns/1ps
module sim_msix_msg_gen;
  localparam int NV = 8;
  localparam int NVEC_T = 8;
  // {status pattern, expected vector set}
  localparam logic [39:0] VECS [NVEC_T] = '{
    {32'h0000_0001, 8'h01},   // R2
    {32'h0000_0080, 8'h80},   // R2
    {32'h8000_0000, 8'h04},   // R3
    {32'h8000_0004, 8'h04},   // R3 single message
    {32'h0000_00A5, 8'hA5},   // R8 order
    {32'h0000_0F00, 8'h00},   // R2 beyond table
    {32'h0000_00FF, 8'hFF},   // R8
    {32'h8000_0010, 8'h14}    // R3 with R8
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_req = 0, reg_we = 0;
  logic [10:0] reg_waddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic msix_en = 1'b1, func_mask = 1'b0, wr_ready = 1'b1;
  logic [31:0] irq_status = '0, irq_mask = '0;
  logic wr_valid, intx_n;
  logic [63:0] wr_addr;
  logic [31:0] wr_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  msix_msg_gen #(.NUM_VEC(NV)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msix_en(msix_en), .func_mask(func_mask), .irq_status(irq_status),
    .irq_mask(irq_mask), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .intx_n(intx_n));

  function automatic logic [63:0] exp_addr(int k);
    return {32'h0000_0100 + 32'(k), 32'hFEE0_0000 + 32'(k * 16)};
  endfunction
  function automatic logic [31:0] exp_data(int k);
    return 32'hA500_0000 + 32'(k);
  endfunction
  function automatic logic [10:0] vw(int k, int w);
    return 11'(32'h400 + k * 4 + w);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_waddr = a;
    #1 d = reg_rdata;
  endtask

  // Gather messages for a while; compare to the expected set in ascending order
  task automatic collect(input logic [7:0] exp_set, input string req);
    logic [7:0] left = exp_set;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (wr_valid && wr_ready) begin
        int k = -1;
        for (int i = NV - 1; i >= 0; i--) if (left[i]) k = i;
        if (k < 0) check(0, {req, " unexpected message"}, wr_addr, 0);
        else begin
          check(wr_addr == exp_addr(k) && wr_data == exp_data(k), req,
                {wr_addr[39:0], wr_data[23:0]}, {exp_addr(k), exp_data(k)} );
          left[k] = 1'b0;
        end
      end
    end
    check(left == 0, {req, " missing messages"}, 64'(left), 0);
  endtask

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // Reset state
    check(!wr_valid, "R9 reset valid", 64'(wr_valid), 0);
    check(intx_n, "R11 reset intx_n", 64'(intx_n), 1);
    rd(vw(0, 3), d); check(d == 1, "R4 mask resets set", d, 1);
    rd(11'h600, d);  check(d == 0, "R5 pending reset", d, 0);
    // Program vectors
    for (int k = 0; k < NV; k++) begin
      wr(vw(k, 0), exp_addr(k)[31:0]);
      wr(vw(k, 1), exp_addr(k)[63:32]);
      wr(vw(k, 2), exp_data(k));
      wr(vw(k, 3), 32'h0);
    end
    rd(vw(5, 2), d); check(d == exp_data(5), "R4 readback data", d, exp_data(5));
    rd(vw(5, 1), d); check(d == exp_addr(5)[63:32], "R4 readback addr hi", d, exp_addr(5)[63:32]);
    wr(vw(8, 2), 32'hDEAD_BEEF);
    rd(vw(8, 2), d); check(d == 0, "R4 unimplemented vector", d, 0);
    rd(11'h000, d);  check(d == 0, "R4 control area", d, 0);

    // Vector table walk (R1, R2, R3, R8)
    for (int v = 0; v < NVEC_T; v++) begin
      @(negedge clk); irq_status = VECS[v][39:8];
      collect(VECS[v][7:0], $sformatf("R1 R2 R3 R8 vector %0d", v));
      @(negedge clk); irq_status = '0;
      repeat (3) @(negedge clk);
    end

    // R6, R10, R5, R7: masked vector
    wr(vw(3, 3), 32'h1);
    @(negedge clk); irq_status = 32'h8;
    collect(8'h00, "R6 masked silent");
    rd(11'h600, d); check(d == 32'h8, "R6 pending set", d, 8);
    @(negedge clk); irq_status = 0;
    @(negedge clk); irq_status = 32'h8;
    repeat (3) @(negedge clk);
    wr(11'h600, 32'hFFFF_FFFF);
    rd(11'h600, d); check(d == 32'h8, "R5 pending write ignored", d, 8);
    wr(vw(3, 3), 32'h0);
    collect(8'h08, "R7 R10 one message on unmask");
    rd(11'h600, d); check(d == 0, "R7 pending cleared", d, 0);
    @(negedge clk); irq_status = 0;

    // R6, R7: function mask
    @(negedge clk); func_mask = 1; irq_status = 32'h2;
    collect(8'h00, "R6 function mask silent");
    rd(11'h600, d); check(d == 32'h2, "R6 function mask pending", d, 2);
    @(negedge clk); func_mask = 0;
    collect(8'h02, "R7 function mask release");
    @(negedge clk); irq_status = 0;

    // R9, R10: stall with re-trigger
    @(negedge clk); wr_ready = 0; irq_status = 32'h1;
    for (int c = 0; c < 10 && !wr_valid; c++) @(negedge clk);
    check(wr_valid && wr_addr == exp_addr(0), "R9 stalled message", wr_addr, exp_addr(0));
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); irq_status = (c % 2 == 0) ? 32'h0 : 32'h1;
      check(wr_valid && wr_addr == exp_addr(0) && wr_data == exp_data(0),
            "R9 hold under stall", wr_addr, exp_addr(0));
    end
    @(negedge clk); wr_ready = 1;
    @(negedge clk); check(!wr_valid, "R8 valid drops after accept", 64'(wr_valid), 0);
    collect(8'h00, "R10 no duplicate after stall");
    @(negedge clk); irq_status = 0;

    // R11, R12: legacy mode
    @(negedge clk); msix_en = 0; irq_status = 32'h10;
    collect(8'h00, "R12 disabled silent");
    rd(11'h600, d); check(d == 0, "R12 no pending when disabled", d, 0);
    check(!intx_n, "R11 intx asserted", 64'(intx_n), 0);
    @(negedge clk); irq_mask = 32'h10;
    #1 check(intx_n, "R11 intx masked", 64'(intx_n), 1);
    @(negedge clk); irq_mask = 0; msix_en = 1;
    #1 check(intx_n, "R11 intx quiet when enabled", 64'(intx_n), 1);
    collect(8'h00, "R12 no late message");
    @(negedge clk); irq_status = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule